// File: doc/BRIEF.md
# Programmable Card Clock Divider with Safe Ratio Reload

This block turns a fast master clock into the two timing signals a smart card interface needs. The first is a prescale tick: a single-cycle enable pulse that comes once every (N + 1) master cycles. It paces an elementary-time-unit counter that sits downstream. The second is a square-wave card clock that toggles on every tick, so it runs at half the tick rate with equal high and low phases.

N is a 6-bit divisor held in an 8-bit configuration register. Software may rewrite it at any moment through a write strobe and a data byte. The written byte is visible at once on the read port. The divider itself picks up the new divisor only when a full card clock period ends, which is the tick on which the card clock falls. The card clock therefore never shows a runt pulse or a phase shorter than a whole period of either the old or the new ratio. A divisor of zero acts as one. Two instances of the block can drive independent internal and external card clocks.

Top module: `sccd_top`

## Requirements
- R1: While reset (active-low, synchronous) is applied, the register reads 0x0C, the card clock is low and the tick is low. After release, the first card clock low phase lasts 13 master cycles and the first high phase also lasts 13.
- R2: The tick is high for exactly one master cycle and comes every (N + 1) master cycles, where N is the active divisor. Exactly one tick falls within each card clock phase, in that phase's last cycle.
- R3: The card clock toggles in the cycle after each tick and holds its level otherwise, so every high or low phase lasts N + 1 master cycles.
- R4: A divisor of 0 behaves exactly like 1: each card clock phase is 2 master cycles long.
- R5: Only bits 5:0 of a written byte are stored. Bits 7:6 always read as zero and have no effect on the ratio, so writing 0xFF gives 64-cycle phases and 0xC2 gives 3-cycle phases.
- R6: The cycle after a write, the read port returns the written value (bits 7:6 cleared). This happens even while the divider is still running the old ratio, and the read port holds its value while no write occurs.
- R7: A stored divisor becomes active only on the tick that ends a high phase. When a write lands mid-period, both phases of the card period already in progress keep the old ratio, and the following periods use the new one.
- R8: When a write lands in the same cycle as that reload tick, the reload takes the previously stored divisor. The new value then takes effect one full card period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data; bits 5:0 carry the divisor |
| rd_data | output | 8 | Current register contents, bits 7:6 zero |
| tick | output | 1 | One-cycle prescale enable for the ETU counter |
| card_clk | output | 1 | 50% duty card clock, toggling on each tick |

## Verification
A register write can land in the same master cycle as the reload tick at the end of a card period. The bench provokes this on purpose. It watches for the card clock rising and then counts the high phase length, minus one, in cycles before it asserts the strobe, so the strobe meets the falling tick exactly. It judges the outcome by phase lengths: one more full period at the old ratio, and only then the new one. Mid-period writes are judged the same way. Each measured phase is checked against a queue of predicted lengths, and each phase must contain exactly one tick.

// File: rtl/sccd_pkg.sv
package sccd_pkg;
  localparam int REG_W_DEF = 8;
  localparam int DIV_W_DEF = 6;
  localparam int RESET_DIV_DEF = 12;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/sccd_cfg_reg.sv
module sccd_cfg_reg #(
  parameter int REG_W = 8,
  parameter int DIV_W = 6,
  parameter int RESET_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [DIV_W-1:0] shadow_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int RSV_W = REG_W - DIV_W;
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
    end else if (wr_en_i) begin
      shadow_q <= wr_data_i[DIV_W-1:0];
    end
  end

  assign shadow_o = shadow_q;

  // Reserved upper bits are dropped on write and read back as zero.
  generate
    if (RSV_W > 0) begin : g_pad
      logic unused_rsv;
      assign unused_rsv = ^wr_data_i[REG_W-1:DIV_W];
      assign rd_data_o  = {{RSV_W{1'b0}}, shadow_q};
    end else begin : g_flat
      assign rd_data_o = shadow_q;
    end
  endgenerate
endmodule

// File: rtl/sccd_prescaler.sv
module sccd_prescaler #(
  parameter int DIV_W = 6,
  parameter int RESET_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] shadow_i,
  input  logic             reload_ok_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] ratio_o
);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] ratio_next;
  logic             load_en;

  // A zero divisor is treated as one.
  assign ratio_next = (shadow_i == '0) ? ONE : shadow_i;
  assign tick_o     = (cnt_q == ratio_q);
  // Reload only at the wrap that also closes a full card period.
  assign load_en    = tick_o & reload_ok_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RST_VAL;
    end else begin
      if (tick_o) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
      if (load_en) begin
        ratio_q <= ratio_next;
      end
    end
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/sccd_phase.sv
module sccd_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic card_clk_o
);
  import sccd_pkg::*;

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
    end else if (tick_i) begin
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end
  end

  assign card_clk_o = (phase_q == PH_HIGH);
endmodule

// File: rtl/sccd_top.sv
module sccd_top #(
  parameter int REG_W = sccd_pkg::REG_W_DEF,
  parameter int DIV_W = sccd_pkg::DIV_W_DEF,
  parameter int RESET_DIV = sccd_pkg::RESET_DIV_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick,
  output logic             card_clk
);
  logic [DIV_W-1:0] shadow;
  logic [DIV_W-1:0] ratio_q;

  sccd_cfg_reg #(
    .REG_W(REG_W),
    .DIV_W(DIV_W),
    .RESET_DIV(RESET_DIV)
  ) u_cfg (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en_i(wr_en),
    .wr_data_i(wr_data),
    .shadow_o(shadow),
    .rd_data_o(rd_data)
  );

  sccd_prescaler #(
    .DIV_W(DIV_W),
    .RESET_DIV(RESET_DIV)
  ) u_presc (
    .clk(clk),
    .rst_n(rst_n),
    .shadow_i(shadow),
    .reload_ok_i(card_clk),
    .tick_o(tick),
    .ratio_o(ratio_q)
  );

  sccd_phase u_phase (
    .clk(clk),
    .rst_n(rst_n),
    .tick_i(tick),
    .card_clk_o(card_clk)
  );
endmodule

// File: rtl/sccd_top_chk.sv
module sccd_top_chk #(
  parameter int REG_W = 8,
  parameter int DIV_W = 6,
  parameter int RESET_DIV = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             tick,
  input logic             card_clk,
  input logic [DIV_W-1:0] ratio_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!card_clk && !tick && rd_data == REG_W'(RESET_DIV)));

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (card_clk != $past(card_clk)));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(card_clk));

  // R4
  ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q != '0);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:DIV_W] == '0);

  // R6
  rd_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == REG_W'($past(wr_data[DIV_W-1:0]))));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && card_clk) |=> $stable(ratio_q));

  // R8
  reload_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && card_clk && wr_en) |=>
      (ratio_q == (($past(rd_data[DIV_W-1:0]) == '0) ? DIV_W'(1)
                                                     : $past(rd_data[DIV_W-1:0]))));
endmodule

bind sccd_top sccd_top_chk #(
  .REG_W(REG_W),
  .DIV_W(DIV_W),
  .RESET_DIV(RESET_DIV)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .wr_en(wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .tick(tick),
  .card_clk(card_clk),
  .ratio_q(ratio_q)
);

// File: tb/sccd_top_bench.sv
module sccd_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tick;
  logic       card_clk;

  always #5 clk = ~clk;

  sccd_top u_sccd_top (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .tick(tick),
    .card_clk(card_clk)
  );

  typedef struct {
    int    len;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   rises = 0;
  int   falls = 0;
  int   cur = 13;
  bit   armed = 1'b0;
  bit   done = 1'b0;
  logic prev_clk = 1'b0;
  int   len = 0;
  int   tcnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int ratio_of(input int v);
    int d;
    d = v & 63;
    return ((d == 0) ? 1 : d) + 1;
  endfunction

  task automatic push(input int n, input string tag);
    exp_t e;
    e.len = n;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: measures phase lengths and ticks per phase, pops predictions.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (!armed) begin
        if (card_clk !== prev_clk) begin
          armed = 1'b1;
          len = 1;
          tcnt = tick ? 1 : 0;
          rises++;
        end
        prev_clk = card_clk;
      end else if (card_clk !== prev_clk) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected phase", len, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(len == e.len, e.tag, len, e.len);
        end
        check(tcnt == 1, "R2 ticks per phase", tcnt, 1);
        if (card_clk) rises++;
        else falls++;
        len = 1;
        tcnt = tick ? 1 : 0;
        prev_clk = card_clk;
      end else begin
        len++;
        tcnt += tick ? 1 : 0;
      end
    end
  end

  task automatic do_write(input logic [7:0] d, input string tag);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
    check(rd_data == (d & 8'h3F), tag, rd_data, d & 8'h3F);
  endtask

  // Called at the sample where a fall was just seen; write lands mid-period.
  task automatic mid_write(input logic [7:0] v, input int d, input string tag);
    int base;
    int nr;
    base = falls;
    push(cur, "R7 old ratio low phase");
    push(cur, "R7 old ratio high phase");
    repeat (d) @(negedge clk);
    do_write(v, "R6 read before active");
    nr = ratio_of(v);
    for (int i = 0; i < 4; i++) push(nr, tag);
    wait (falls >= base + 3);
    cur = nr;
  endtask

  // Called at a fall; write strobe meets the reload tick that ends the period.
  task automatic coin_write(input logic [7:0] v, input string tag);
    int base;
    int r0;
    int nr;
    base = falls;
    push(cur, "R8 running period low");
    push(cur, "R8 running period high");
    push(cur, "R8 previous value reloaded low");
    push(cur, "R8 previous value reloaded high");
    r0 = rises;
    wait (rises != r0);
    repeat (cur - 1) @(negedge clk);
    do_write(v, "R6 read on coincident write");
    nr = ratio_of(v);
    push(nr, tag);
    push(nr, tag);
    wait (falls >= base + 3);
    cur = nr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h0C, "R1 reset register value", rd_data, 8'h0C);
    check(card_clk == 1'b0, "R1 reset card clock", card_clk, 0);
    check(tick == 1'b0, "R1 reset tick", tick, 0);
    rst_n = 1'b1;
    push(13, "R1 default high phase");
    c = 0;
    while (card_clk == 1'b0 && c < 100) begin
      @(negedge clk);
      c++;
    end
    check(c == 13, "R1 default low phase", c, 13);
    wait (falls >= 1);
    cur = 13;

    mid_write(8'h05, 4, "R3 ratio 6 phase");
    mid_write(8'h00, 3, "R4 zero acts as one");
    mid_write(8'h01, 1, "R4 one gives ratio 2");
    mid_write(8'hFF, 2, "R5 reserved bits ignored 0xFF");
    coin_write(8'h03, "R8 new value after extra period");
    mid_write(8'hC2, 5, "R5 reserved bits ignored 0xC2");
    coin_write(8'h00, "R8 coincident zero write");

    check(exp_q.size() == 0, "R7 all predicted phases seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule